// File: doc/BRIEF.md
# Control-Word Majority Decoder With Hold

This block decodes recovered 20-bit words on the receive side of a serial video link. One word arrives per parallel clock. Each word comes with a valid strobe. Two fixed transition patterns mark the switch between the control phase and the video phase, and the block tracks the current phase from them. Each payload may have been sent inverted to keep the line balanced. Bit 0 of every word says whether that happened, and the block undoes the inversion before it decodes anything.

In the video phase, the block presents the 18 payload bits as pixel data. In the control phase, it recovers nine control bits. The first five are each carried three times and recovered by a 2-of-3 vote, so a single wrong copy in a group has no effect. The other four are carried once. Each output group keeps its last value while the link is in the other phase or sending transition words. A recovered data enable shows which phase is in force.

Top module: `ctl_vote_decoder`

## Requirements
- R1: While reset is high and on the first cycle after it, `vid_o` and `ctl_o` are zero and `de_o` and `err_o` are low. The block starts in the control phase.
- R2: Bit 0 of a word is the inversion flag. In a control word, bits 19:1 form mapped positions m0..m18. Control bit k (k = 0..4) is carried at m(3k), m(3k+1) and m(3k+2). Control bit 5+j (j = 0..3) is carried at m(15+j).
- R3: Each of control bits 0..4 takes the value held by at least two of its three copies, so any single-bit error within a group is corrected.
- R4: Each of control bits 5..8 takes the value of its one mapped position, so an error there passes through to the output.
- R5: When bit 0 is 1, the payload (bits 19:1 of a control word, bits 19:2 of a video word) is inverted before it is decoded or voted.
- R6: The word 20'hFFC00 switches to the video phase and the word 20'h003FF switches to the control phase. `de_o` is high from the cycle after a video transition word and low from the cycle after a control transition word. No other word changes the phase, and transition words never change data outputs.
- R7: `ctl_o` updates one cycle after each valid control-phase word and holds its value through the transition words and the whole video phase.
- R8: In a video word, bit 1 is the check bit and bits 19:2 are the pixel payload. `vid_o` updates one cycle after each valid, well-coded video word and holds its value through the transition words and the whole control phase.
- R9: A video word whose bit 1 equals its bit 0 raises `err_o` for exactly one cycle and leaves `vid_o` unchanged.
- R10: A word presented with `valid_i` low changes no output and no phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock |
| rst | input | 1 | Synchronous active-high reset |
| word_i | input | 20 | Recovered word, bit 0 received first |
| valid_i | input | 1 | Word qualifier |
| vid_o | output | 18 | Held pixel data |
| ctl_o | output | 9 | Held control bits |
| de_o | output | 1 | Recovered data enable (video phase) |
| err_o | output | 1 | One-cycle coding-error pulse |

## Verification
The inversion step and the majority vote can both act on the same control word, because an inverted word may also carry a flipped copy. Both must resolve in that word's single decode cycle. The bench provokes this by sweeping every protected copy position as a one-bit error in words sent both plain and inverted. It judges the result by comparing `ctl_o` with the original control value, which it computes independently of the design. A second overlap is a phase change right after a held value: the bench checks that the other group stays frozen in the very cycle `de_o` flips.

// File: rtl/cvd_pkg.sv
package cvd_pkg;
  localparam int INV_POS = 0;
  localparam int CHK_POS = 1;
  localparam logic [19:0] TW_TO_VID = 20'hFFC00;
  localparam logic [19:0] TW_TO_CTL = 20'h003FF;
endpackage

// File: rtl/cvd_phase_track.sv
module cvd_phase_track #(
  parameter int WORD_W = 20,
  parameter logic [WORD_W-1:0] TW_VID = '1,
  parameter logic [WORD_W-1:0] TW_CTL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              is_trans_o,
  output logic              vid_phase_o
);
  logic hit_vid, hit_ctl;

  assign hit_vid    = valid_i && (word_i == TW_VID);
  assign hit_ctl    = valid_i && (word_i == TW_CTL);
  assign is_trans_o = hit_vid || hit_ctl;

  always_ff @(posedge clk) begin
    if (rst)          vid_phase_o <= 1'b0;
    else if (hit_vid) vid_phase_o <= 1'b1;
    else if (hit_ctl) vid_phase_o <= 1'b0;
  end

  // R6: phase moves only after a transition word
  a_r6_phase_needs_tw: assert property (@(posedge clk) disable iff (rst)
    (vid_phase_o != $past(vid_phase_o)) |-> $past(is_trans_o));
  a_r6_vid_tw_sets: assert property (@(posedge clk) disable iff (rst)
    hit_vid |=> vid_phase_o);
endmodule

// File: rtl/cvd_ctl_vote.sv
module cvd_ctl_vote #(
  parameter int N_PROT  = 5,
  parameter int COPIES  = 3,
  parameter int N_PLAIN = 4,
  localparam int MAP_W  = N_PROT*COPIES + N_PLAIN,
  localparam int CTL_W  = N_PROT + N_PLAIN
) (
  input  logic [MAP_W-1:0] map_i,
  output logic [CTL_W-1:0] ctl_o
);
  for (genvar k = 0; k < N_PROT; k++) begin : g_prot
    logic [COPIES-1:0] grp;
    assign grp      = map_i[k*COPIES +: COPIES];
    assign ctl_o[k] = ($countones(grp) > (COPIES/2));
  end

  for (genvar j = 0; j < N_PLAIN; j++) begin : g_plain
    assign ctl_o[N_PROT+j] = map_i[N_PROT*COPIES + j];
  end
endmodule

// File: rtl/ctl_vote_decoder.sv
module ctl_vote_decoder
  import cvd_pkg::*;
#(
  parameter int VID_W   = 18,
  parameter int N_PROT  = 5,
  parameter int COPIES  = 3,
  parameter int N_PLAIN = 4,
  localparam int WORD_W = VID_W + 2,
  localparam int MAP_W  = WORD_W - 1,
  localparam int CTL_W  = N_PROT + N_PLAIN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word_i,
  input  logic              valid_i,
  output logic [VID_W-1:0]  vid_o,
  output logic [CTL_W-1:0]  ctl_o,
  output logic              de_o,
  output logic              err_o
);
  logic             inv, chk_bad, is_trans;
  logic [VID_W-1:0] vid_pay;
  logic [MAP_W-1:0] map_pay;
  logic [CTL_W-1:0] ctl_dec;
  logic             take;

  assign inv     = word_i[INV_POS];
  assign chk_bad = (word_i[CHK_POS] == word_i[INV_POS]);
  assign vid_pay = word_i[WORD_W-1:2] ^ {VID_W{inv}};
  assign map_pay = word_i[WORD_W-1:1] ^ {MAP_W{inv}};
  assign take    = valid_i && !is_trans;

  cvd_phase_track #(
    .WORD_W(WORD_W), .TW_VID(TW_TO_VID), .TW_CTL(TW_TO_CTL)
  ) u_phase (
    .clk(clk), .rst(rst), .valid_i(valid_i), .word_i(word_i),
    .is_trans_o(is_trans), .vid_phase_o(de_o)
  );

  cvd_ctl_vote #(
    .N_PROT(N_PROT), .COPIES(COPIES), .N_PLAIN(N_PLAIN)
  ) u_vote (
    .map_i(map_pay), .ctl_o(ctl_dec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vid_o <= '0;
      ctl_o <= '0;
      err_o <= 1'b0;
    end else begin
      err_o <= 1'b0;
      if (take && de_o) begin
        if (chk_bad) err_o <= 1'b1;
        else         vid_o <= vid_pay;
      end else if (take && !de_o) begin
        ctl_o <= ctl_dec;
      end
    end
  end

  // R3: unanimous copies of control bit 0 must reach the output
  logic grp0_same;
  assign grp0_same = (map_pay[0] == map_pay[1]) && (map_pay[1] == map_pay[2]);

  a_r3_unanimous_bit0: assert property (@(posedge clk) disable iff (rst)
    (take && !de_o && grp0_same) |=> (ctl_o[0] == $past(map_pay[0])));
  a_r7_ctl_hold_in_video: assert property (@(posedge clk) disable iff (rst)
    $past(de_o) |-> $stable(ctl_o));
  a_r8_vid_hold_in_ctl: assert property (@(posedge clk) disable iff (rst)
    !$past(de_o) |-> $stable(vid_o));
  a_r9_err_keeps_vid: assert property (@(posedge clk) disable iff (rst)
    err_o |-> ($stable(vid_o) && $past(de_o)));
  a_r10_idle_no_change: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> ($stable(vid_o) && $stable(ctl_o) && $stable(de_o) && !err_o));
endmodule

// File: tb/ctl_vote_decoder_tb.sv
module ctl_vote_decoder_tb;
  localparam logic [19:0] TWV = 20'hFFC00;
  localparam logic [19:0] TWC = 20'h003FF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] word_i = '0;
  logic        valid_i = 1'b0;
  logic [17:0] vid_o;
  logic [8:0]  ctl_o;
  logic        de_o, err_o;

  int checks = 0;
  int errors = 0;
  logic [17:0] exp_vid = '0;
  logic [8:0]  exp_ctl = '0;

  always #5 clk = ~clk;

  ctl_vote_decoder u_dut (
    .clk(clk), .rst(rst), .word_i(word_i), .valid_i(valid_i),
    .vid_o(vid_o), .ctl_o(ctl_o), .de_o(de_o), .err_o(err_o)
  );

  function automatic logic [19:0] mk_ctl(input logic [8:0] c, input logic inv);
    logic [18:0] m;
    for (int k = 0; k < 5; k++) m[3*k +: 3] = {3{c[k]}};
    for (int j = 0; j < 4; j++) m[15+j] = c[5+j];
    return {m ^ {19{inv}}, inv};
  endfunction

  function automatic logic [19:0] mk_vid(input logic [17:0] v, input logic inv, input logic bad);
    return {v ^ {18{inv}}, bad ? inv : ~inv, inv};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [19:0] w, input logic v);
    @(negedge clk);
    word_i  = w;
    valid_i = v;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset vid", 32'(vid_o), 0);
    chk("R1 reset ctl", 32'(ctl_o), 0);
    chk("R1 reset de/err", {30'd0, de_o, err_o}, 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 after reset", {ctl_o, de_o, err_o}, 0);

    // R2 R4 R5: every control value, plain and inverted
    for (int c = 0; c < 512; c++) begin
      for (int i = 0; i < 2; i++) begin
        logic [19:0] w;
        w = mk_ctl(9'(c), 1'(i));
        if (w == TWV || w == TWC) continue;
        send(w, 1'b1);
        exp_ctl = 9'(c);
        chk("R2 R5 ctl decode", 32'(ctl_o), 32'(exp_ctl));
        chk("R8 vid held in ctl", 32'(vid_o), 32'(exp_vid));
      end
    end

    // R3 R4 R5: single-bit error at every mapped position, both polarities
    for (int c = 0; c < 512; c += 37) begin
      for (int i = 0; i < 2; i++) begin
        for (int p = 0; p < 19; p++) begin
          logic [19:0] w;
          logic [8:0]  e;
          w = mk_ctl(9'(c), 1'(i)) ^ (20'd1 << (p + 1));
          if (w == TWV || w == TWC) continue;
          e = 9'(c);
          if (p >= 15) e[p-10] = ~e[p-10];
          send(w, 1'b1);
          exp_ctl = e;
          chk(p < 15 ? "R3 single error corrected" : "R4 plain bit follows",
              32'(ctl_o), 32'(exp_ctl));
        end
      end
    end

    // R3: two wrong copies win the vote
    send(mk_ctl(9'h000, 1'b0) ^ 20'h0000C, 1'b1);
    exp_ctl = 9'h001;
    chk("R3 double error majority", 32'(ctl_o), 32'(exp_ctl));

    // R10: ignored when not valid
    send(mk_ctl(9'h155, 1'b0), 1'b0);
    chk("R10 invalid ctl ignored", 32'(ctl_o), 32'(exp_ctl));
    send(TWV, 1'b0);
    chk("R10 invalid tw ignored", {31'd0, de_o}, 0);

    // R6: into video
    send(TWV, 1'b1);
    chk("R6 de high after tw", {31'd0, de_o}, 1);
    chk("R7 ctl held at tw", 32'(ctl_o), 32'(exp_ctl));
    chk("R8 vid held at tw", 32'(vid_o), 32'(exp_vid));

    // R8 R5 R7: video words
    for (int n = 0; n < 300; n++) begin
      for (int i = 0; i < 2; i++) begin
        logic [17:0] v;
        logic [19:0] w;
        v = 18'((n * 32'd2654435761) >> 7);
        w = mk_vid(v, 1'(i), 1'b0);
        if (w == TWV || w == TWC) continue;
        send(w, 1'b1);
        exp_vid = v;
        chk("R8 R5 vid decode", 32'(vid_o), 32'(exp_vid));
        chk("R7 ctl held in video", 32'(ctl_o), 32'(exp_ctl));
        chk("R9 no err on good word", {31'd0, err_o}, 0);
        chk("R6 de stays high", {31'd0, de_o}, 1);
      end
    end

    // R9: bad check bit
    for (int i = 0; i < 2; i++) begin
      send(mk_vid(18'h2A5A5, 1'(i), 1'b1), 1'b1);
      chk("R9 err pulse", {31'd0, err_o}, 1);
      chk("R9 vid unchanged", 32'(vid_o), 32'(exp_vid));
    end
    send(mk_vid(18'h0F0F0, 1'b0, 1'b0), 1'b1);
    exp_vid = 18'h0F0F0;
    chk("R9 err one cycle", {31'd0, err_o}, 0);
    chk("R8 vid after err", 32'(vid_o), 32'(exp_vid));

    // R6: back to control
    send(TWC, 1'b1);
    chk("R6 de low after tw", {31'd0, de_o}, 0);
    chk("R8 vid held at tw", 32'(vid_o), 32'(exp_vid));
    send(mk_ctl(9'h0A3, 1'b1), 1'b1);
    exp_ctl = 9'h0A3;
    chk("R7 ctl resumes", 32'(ctl_o), 32'(exp_ctl));
    chk("R8 vid held", 32'(vid_o), 32'(exp_vid));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule